// File: doc/BRIEF.md
# Mailbox Channel Window Register Bank

This block holds the shared state of a one-way mailbox between two agents. It has a configurable number of 32-bit channel windows. Each window has a status word, a receiver mask word, a sender interrupt enable and a sender transfer-done flag. The sending agent reaches the bank through the sender register port. It ORs bits into a window's status and polls the status until it drains back to zero. The receiving agent reaches the same status through the receiver register port. There it can mask bits, read the masked view and clear bits it has consumed.

Three kinds of interrupt output are produced. The receiver interrupt fires while any unmasked status bit is set. The sender interrupt reports windows whose status was drained by the receiver. Two per-window combined vectors, one per side, are also readable as four 32-bit words. A request pin and a returned acknowledge give the sender a simple access handshake.

Each register port takes requests on valid/ready. Ready is always high, so a request is accepted in the cycle its valid is high. A read is answered by a response that is valid for exactly one cycle, one clock after acceptance. The response path has no back-pressure, so the requester must be able to take it. Writes produce no response. Word addresses are 11 bits. Bit 10 selects the global registers. Otherwise bits 9:3 give the window index and bits 2:0 give the register inside that window.

Top module: `mbw_bank`

## Requirements
- R1: After reset all status words are 0, all mask words are 0xFFFFFFFF, all enables, done flags and the access request are 0. Both interrupts are low. Global register 0 reads the window count on either port.
- R2: A sender write to window register 1 ORs the write data into that window's status. Window register 0 on either port reads the status.
- R3: A receiver write to window register 2 clears the status bits that are 1 in the data. When a set and a clear hit the same bit in one cycle, the bit ends set.
- R4: A receiver write to window register 4 sets mask bits and one to register 5 clears them. Register 3 reads the mask and register 1 reads status AND NOT mask.
- R5: Receiver combined bit w is 1 when window w has a nonzero masked status. Receiver global registers 4 to 7 read combined bits 0-31, 32-63, 64-95 and 96-127. rx_irq equals the receiver global enable (global register 1, bit 0) ANDed with the OR of the combined bits.
- R6: The sender enable is window register 2 bit 0. The done flag reads at window register 3 bit 0. The flag is set on the clock edge where the status goes from nonzero to zero while the enable is 1. It stays set until the sender writes bit 0 = 1 to window register 3. A set on the same edge beats that clear. A window with enable 0 never sets its flag.
- R7: Sender combined bit w is the done flag of window w. It is read through sender global registers 4 to 7. tx_irq equals the sender global enable (global register 1, bit 0) ANDed with the OR of those bits.
- R8: Sender global register 8 bit 0 drives acc_req. Sender global register 9 reads acc_ack as registered one clock earlier.
- R9: req_ready is always 1. A read accepted on one edge gives rsp_valid high for one cycle after that edge, with the data. A write gives no rsp_valid.
- R10: Accesses to a window index at or above the window count write nothing and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req_valid | input | 1 | Sender request valid |
| s_req_ready | output | 1 | Sender request ready |
| s_req_write | input | 1 | Sender request is a write |
| s_req_addr | input | 11 | Sender word address |
| s_req_wdata | input | 32 | Sender write data |
| s_rsp_valid | output | 1 | Sender read response valid |
| s_rsp_rdata | output | 32 | Sender read data |
| r_req_valid | input | 1 | Receiver request valid |
| r_req_ready | output | 1 | Receiver request ready |
| r_req_write | input | 1 | Receiver request is a write |
| r_req_addr | input | 11 | Receiver word address |
| r_req_wdata | input | 32 | Receiver write data |
| r_rsp_valid | output | 1 | Receiver read response valid |
| r_rsp_rdata | output | 32 | Receiver read data |
| rx_irq | output | 1 | Receiver interrupt |
| tx_irq | output | 1 | Sender transfer-done interrupt |
| rx_comb | output | NUM_WIN | Receiver per-window combined status |
| tx_comb | output | NUM_WIN | Sender per-window combined status |
| acc_req | output | 1 | Access request to the receiver side |
| acc_ack | input | 1 | Access acknowledge from the receiver side |

## Verification
The embedded properties check several rules on every cycle:
- a set beats a same-cycle clear in the status word;
- a clear without a set removes its bits;
- the done flag rises whenever an enabled window drains to zero;
- the done flag holds until it is cleared;
- a response follows only an accepted read.

The bench scenarios show the rest. These are the address decode, the masked view, the combined words and both global enables on the interrupt pins, the race between a done clear and a new completion, the access handshake, and the silence of windows beyond the count.

// File: rtl/mbw_pkg.sv
package mbw_pkg;
  localparam int DW        = 32;
  localparam int ADDR_W    = 11;
  localparam int WIN_IDX_W = 7;
  localparam int REG_W     = 3;
  localparam int MAX_WIN   = 124;
  localparam int COMB_BITS = 128;

  // sender per-window registers
  localparam logic [REG_W-1:0] SW_STATUS = 3'd0;
  localparam logic [REG_W-1:0] SW_SET    = 3'd1;
  localparam logic [REG_W-1:0] SW_IEN    = 3'd2;
  localparam logic [REG_W-1:0] SW_DONE   = 3'd3;
  // receiver per-window registers
  localparam logic [REG_W-1:0] RW_STATUS = 3'd0;
  localparam logic [REG_W-1:0] RW_MASKED = 3'd1;
  localparam logic [REG_W-1:0] RW_CLEAR  = 3'd2;
  localparam logic [REG_W-1:0] RW_MASK   = 3'd3;
  localparam logic [REG_W-1:0] RW_MSET   = 3'd4;
  localparam logic [REG_W-1:0] RW_MCLR   = 3'd5;
  // global registers (low four address bits)
  localparam logic [3:0] G_CFG     = 4'd0;
  localparam logic [3:0] G_COMB_EN = 4'd1;
  localparam logic [3:0] G_ACC_REQ = 4'd8;
  localparam logic [3:0] G_ACC_RDY = 4'd9;

  typedef struct packed {
    logic                 glob;
    logic [WIN_IDX_W-1:0] win;
    logic [REG_W-1:0]     rsel;
  } addr_t;
endpackage

// File: rtl/mbw_window.sv
module mbw_window
  import mbw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic [DW-1:0] set_d,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_d,
  input  logic          mset_we,
  input  logic [DW-1:0] mset_d,
  input  logic          mclr_we,
  input  logic [DW-1:0] mclr_d,
  input  logic          ien_we,
  input  logic          ien_d,
  input  logic          dclr_we,
  output logic [DW-1:0] status,
  output logic [DW-1:0] mask,
  output logic          ien,
  output logic          done
);
  logic [DW-1:0] status_n, mask_n;
  logic          done_n;

  always_comb begin
    status_n = (status & ~(clr_we ? clr_d : '0)) | (set_we ? set_d : '0);
    mask_n   = (mask & ~(mclr_we ? mclr_d : '0)) | (mset_we ? mset_d : '0);
    done_n   = done;
    if (dclr_we) done_n = 1'b0;
    if (ien && (status != '0) && (status_n == '0)) done_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
      ien    <= 1'b0;
      done   <= 1'b0;
    end else begin
      status <= status_n;
      mask   <= mask_n;
      if (ien_we) ien <= ien_d;
      done   <= done_n;
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((status & $past(set_d)) == $past(set_d))); // R3
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((status & $past(clr_d)) == '0)); // R3
  AST_DONE_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    ((status == '0) && ($past(status) != '0) && $past(ien)) |-> done); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && !$past(dclr_we)) |-> done); // R6
endmodule

// File: rtl/mbw_port.sv
module mbw_port
  import mbw_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] rdata_in,
  output logic          req_ready,
  output logic          wr_fire,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  assign req_ready = 1'b1;
  assign wr_fire   = req_valid && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rdata_in : '0;
    end
  end

  AST_RSP_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write)); // R9
  AST_NO_RSP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && req_write) |-> !rsp_valid); // R9
endmodule

// File: rtl/mbw_bank.sv
module mbw_bank
  import mbw_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               s_req_valid,
  output logic               s_req_ready,
  input  logic               s_req_write,
  input  logic [10:0]        s_req_addr,
  input  logic [31:0]        s_req_wdata,
  output logic               s_rsp_valid,
  output logic [31:0]        s_rsp_rdata,
  input  logic               r_req_valid,
  output logic               r_req_ready,
  input  logic               r_req_write,
  input  logic [10:0]        r_req_addr,
  input  logic [31:0]        r_req_wdata,
  output logic               r_rsp_valid,
  output logic [31:0]        r_rsp_rdata,
  output logic               rx_irq,
  output logic               tx_irq,
  output logic [NUM_WIN-1:0] rx_comb,
  output logic [NUM_WIN-1:0] tx_comb,
  output logic               acc_req,
  input  logic               acc_ack
);
  localparam logic [DW-1:0] CFG_VAL = DW'(NUM_WIN);

  addr_t sa, ra;
  assign sa = s_req_addr;
  assign ra = r_req_addr;

  logic s_wr, r_wr;
  logic [DW-1:0] s_rd_n, r_rd_n;
  logic [DW-1:0] status_a [NUM_WIN];
  logic [DW-1:0] mask_a   [NUM_WIN];
  logic          ien_a    [NUM_WIN];
  logic          done_a   [NUM_WIN];
  logic          rx_en_q, tx_en_q, acc_req_q, acc_rdy_q;

  mbw_port u_sport (
    .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_write(s_req_write),
    .rdata_in(s_rd_n), .req_ready(s_req_ready), .wr_fire(s_wr),
    .rsp_valid(s_rsp_valid), .rsp_rdata(s_rsp_rdata));

  mbw_port u_rport (
    .clk(clk), .rst_n(rst_n), .req_valid(r_req_valid), .req_write(r_req_write),
    .rdata_in(r_rd_n), .req_ready(r_req_ready), .wr_fire(r_wr),
    .rsp_valid(r_rsp_valid), .rsp_rdata(r_rsp_rdata));

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic s_hit, r_hit;
    assign s_hit = s_wr && !sa.glob && (sa.win == WIN_IDX_W'(w));
    assign r_hit = r_wr && !ra.glob && (ra.win == WIN_IDX_W'(w));

    mbw_window u_win (
      .clk(clk), .rst_n(rst_n),
      .set_we (s_hit && sa.rsel == SW_SET),    .set_d (s_req_wdata),
      .clr_we (r_hit && ra.rsel == RW_CLEAR),  .clr_d (r_req_wdata),
      .mset_we(r_hit && ra.rsel == RW_MSET),   .mset_d(r_req_wdata),
      .mclr_we(r_hit && ra.rsel == RW_MCLR),   .mclr_d(r_req_wdata),
      .ien_we (s_hit && sa.rsel == SW_IEN),    .ien_d (s_req_wdata[0]),
      .dclr_we(s_hit && sa.rsel == SW_DONE && s_req_wdata[0]),
      .status(status_a[w]), .mask(mask_a[w]), .ien(ien_a[w]), .done(done_a[w]));

    assign rx_comb[w] = |(status_a[w] & ~mask_a[w]);
    assign tx_comb[w] = done_a[w];
  end

  logic [COMB_BITS-1:0] rx_comb_w, tx_comb_w;
  assign rx_comb_w = COMB_BITS'(rx_comb);
  assign tx_comb_w = COMB_BITS'(tx_comb);
  assign rx_irq    = rx_en_q && (|rx_comb);
  assign tx_irq    = tx_en_q && (|tx_comb);
  assign acc_req   = acc_req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_en_q   <= 1'b0;
      tx_en_q   <= 1'b0;
      acc_req_q <= 1'b0;
      acc_rdy_q <= 1'b0;
    end else begin
      acc_rdy_q <= acc_ack;
      if (s_wr && sa.glob && sa[3:0] == G_COMB_EN) tx_en_q   <= s_req_wdata[0];
      if (s_wr && sa.glob && sa[3:0] == G_ACC_REQ) acc_req_q <= s_req_wdata[0];
      if (r_wr && ra.glob && ra[3:0] == G_COMB_EN) rx_en_q   <= r_req_wdata[0];
    end
  end

  // sender read mux
  always_comb begin
    s_rd_n = '0;
    if (sa.glob) begin
      unique case (sa[3:0])
        G_CFG:     s_rd_n = CFG_VAL;
        G_COMB_EN: s_rd_n = DW'(tx_en_q);
        4'd4, 4'd5, 4'd6, 4'd7: s_rd_n = tx_comb_w[32*sa[1:0] +: 32];
        G_ACC_REQ: s_rd_n = DW'(acc_req_q);
        G_ACC_RDY: s_rd_n = DW'(acc_rdy_q);
        default:   s_rd_n = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (sa.win == WIN_IDX_W'(i)) begin
          unique case (sa.rsel)
            SW_STATUS: s_rd_n = status_a[i];
            SW_IEN:    s_rd_n = DW'(ien_a[i]);
            SW_DONE:   s_rd_n = DW'(done_a[i]);
            default:   s_rd_n = '0;
          endcase
        end
      end
    end
  end

  // receiver read mux
  always_comb begin
    r_rd_n = '0;
    if (ra.glob) begin
      unique case (ra[3:0])
        G_CFG:     r_rd_n = CFG_VAL;
        G_COMB_EN: r_rd_n = DW'(rx_en_q);
        4'd4, 4'd5, 4'd6, 4'd7: r_rd_n = rx_comb_w[32*ra[1:0] +: 32];
        default:   r_rd_n = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_WIN; i++) begin
        if (ra.win == WIN_IDX_W'(i)) begin
          unique case (ra.rsel)
            RW_STATUS: r_rd_n = status_a[i];
            RW_MASKED: r_rd_n = status_a[i] & ~mask_a[i];
            RW_MASK:   r_rd_n = mask_a[i];
            default:   r_rd_n = '0;
          endcase
        end
      end
    end
  end

  initial begin
    AST_WIN_COUNT: assert (NUM_WIN >= 1 && NUM_WIN <= MAX_WIN); // R10
  end
endmodule

// File: tb/sim_mbw_bank.sv
module sim_mbw_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic s_req_valid = 0, s_req_write = 0, r_req_valid = 0, r_req_write = 0;
  logic [10:0] s_req_addr = '0, r_req_addr = '0;
  logic [31:0] s_req_wdata = '0, r_req_wdata = '0;
  logic s_req_ready, r_req_ready, s_rsp_valid, r_rsp_valid;
  logic [31:0] s_rsp_rdata, r_rsp_rdata;
  logic rx_irq, tx_irq, acc_req;
  logic acc_ack = 1'b0;
  logic [3:0] rx_comb, tx_comb;

  mbw_bank #(.NUM_WIN(4)) u0 (.*);

  always @(posedge clk) acc_ack <= acc_req;

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit rx, input logic [10:0] a, input logic [31:0] d);
    @(negedge clk);
    if (rx) begin r_req_valid = 1; r_req_write = 1; r_req_addr = a; r_req_wdata = d; end
    else    begin s_req_valid = 1; s_req_write = 1; s_req_addr = a; s_req_wdata = d; end
    @(negedge clk);
    s_req_valid = 0; s_req_write = 0; r_req_valid = 0; r_req_write = 0;
  endtask

  task automatic rd(input bit rx, input logic [10:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    if (rx) begin r_req_valid = 1; r_req_write = 0; r_req_addr = a; end
    else    begin s_req_valid = 1; s_req_write = 0; s_req_addr = a; end
    @(negedge clk);
    s_req_valid = 0; r_req_valid = 0;
    d = rx ? r_rsp_rdata : s_rsp_rdata;
    v = rx ? r_rsp_valid : s_rsp_valid;
  endtask

  task automatic wr_both(input logic [10:0] sa, input logic [31:0] sd,
                         input logic [10:0] ra, input logic [31:0] rdd);
    @(negedge clk);
    s_req_valid = 1; s_req_write = 1; s_req_addr = sa; s_req_wdata = sd;
    r_req_valid = 1; r_req_write = 1; r_req_addr = ra; r_req_wdata = rdd;
    @(negedge clk);
    s_req_valid = 0; s_req_write = 0; r_req_valid = 0; r_req_write = 0;
  endtask

  // {rx, write, addr, data, expected, req}
  localparam int NV = 17;
  localparam logic [80:0] VEC [NV] = '{
    {1'b0, 1'b1, 11'd1,     32'h000000A5, 32'h0,        4'd2},  // R2 set w0
    {1'b0, 1'b0, 11'd0,     32'h0,        32'h000000A5, 4'd2},  // R2 sender status
    {1'b1, 1'b0, 11'd0,     32'h0,        32'h000000A5, 4'd2},  // R2 receiver status
    {1'b1, 1'b0, 11'd1,     32'h0,        32'h0,        4'd4},  // R4 fully masked at reset
    {1'b1, 1'b1, 11'd5,     32'h0000000F, 32'h0,        4'd4},  // R4 mask clear
    {1'b1, 1'b0, 11'd1,     32'h0,        32'h00000005, 4'd4},  // R4 masked view
    {1'b1, 1'b0, 11'd3,     32'h0,        32'hFFFFFFF0, 4'd4},  // R4 mask read
    {1'b1, 1'b1, 11'd2,     32'h00000005, 32'h0,        4'd3},  // R3 clear
    {1'b1, 1'b0, 11'd0,     32'h0,        32'h000000A0, 4'd3},  // R3 status after clear
    {1'b0, 1'b1, 11'd17,    32'h80000000, 32'h0,        4'd2},  // R2 set w2
    {1'b1, 1'b1, 11'd21,    32'hFFFFFFFF, 32'h0,        4'd4},  // R4 unmask w2
    {1'b1, 1'b0, 11'd17,    32'h0,        32'h80000000, 4'd4},  // R4 masked w2
    {1'b1, 1'b0, 11'h404,   32'h0,        32'h00000004, 4'd5},  // R5 comb word 0
    {1'b0, 1'b1, 11'd41,    32'h0000FFFF, 32'h0,        4'd10}, // R10 set w5
    {1'b0, 1'b0, 11'd40,    32'h0,        32'h0,        4'd10}, // R10 read w5
    {1'b1, 1'b0, 11'h400,   32'h0,        32'h00000004, 4'd1},  // R1 count
    {1'b0, 1'b0, 11'h404,   32'h0,        32'h0,        4'd7}   // R7 no done yet
  };

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rx_irq", 32'(rx_irq), 0);
    chk("R1 tx_irq", 32'(tx_irq), 0);
    chk("R1 acc_req", 32'(acc_req), 0);
    chk("R9 req_ready", 32'({s_req_ready, r_req_ready}), 32'h3);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][79]) wr(VEC[i][80], VEC[i][78:68], VEC[i][67:36]);
      else begin
        rd(VEC[i][80], VEC[i][78:68], d, v);
        chk($sformatf("R%0d vector %0d", VEC[i][3:0], i), d, VEC[i][35:4]);
      end
    end

    // R5 receiver enable and irq
    wr(1, 11'h401, 1);
    chk("R5 rx_irq on", 32'(rx_irq), 1);
    wr(1, 11'd18, 32'h80000000);
    chk("R5 rx_irq off", 32'(rx_irq), 0);

    // R6 / R7 done flag
    wr(0, 11'd2, 1);
    wr(1, 11'd2, 32'hFFFFFFFF);
    chk("R9 no rsp on write", 32'(r_rsp_valid), 0);
    rd(0, 11'd3, d, v);
    chk("R6 done set", d, 1);
    chk("R9 rsp valid on read", 32'(v), 1);
    chk("R7 tx_irq gated", 32'(tx_irq), 0);
    rd(0, 11'h404, d, v);
    chk("R7 comb word", d, 1);
    wr(0, 11'h401, 1);
    chk("R7 tx_irq on", 32'(tx_irq), 1);
    wr(0, 11'd3, 1);
    chk("R6 tx_irq cleared", 32'(tx_irq), 0);
    rd(0, 11'd3, d, v);
    chk("R6 done cleared", d, 0);

    // R3 set beats clear on same bit
    wr(0, 11'd25, 32'h2);
    wr_both(11'd25, 32'h1, 11'd26, 32'h3);
    rd(1, 11'd24, d, v);
    chk("R3 set wins", d, 32'h1);

    // R6 new completion beats done clear
    wr(0, 11'd9, 1);
    wr(0, 11'd10, 1);
    wr_both(11'd11, 32'h1, 11'd10, 32'h1);
    rd(0, 11'd11, d, v);
    chk("R6 set beats clear", d, 1);
    chk("R7 tx_irq again", 32'(tx_irq), 1);

    // R8 access handshake
    rd(0, 11'h409, d, v);
    chk("R8 ready low", d, 0);
    wr(0, 11'h408, 1);
    chk("R8 acc_req high", 32'(acc_req), 1);
    repeat (3) @(negedge clk);
    rd(0, 11'h409, d, v);
    chk("R8 ready high", d, 1);
    wr(0, 11'h408, 0);
    chk("R8 acc_req released", 32'(acc_req), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule